// File: doc/BRIEF.md
# Polled Keyboard and Display Register Window

This block lets a 16-bit processor reach a character input device and a character output device through its ordinary load and store cycles. Four device registers are placed at fixed addresses. For each device there is a status word and a data word. The processor polls a ready flag in bit 15 of each status word, which makes a simple handshake between software and the device. It then moves one character through the matching data word.

On the device side, a keyboard source presents a byte together with a one-cycle valid strobe. A display sink receives a byte through a valid/ready handshake. A select output tells the system bus whether the block claims the current access. When the block does not claim an access, memory answers that address instead. Read data is combinational from the addressed register. The side effects of a read, which clear flags, take place at the clock edge that ends the access.

Top module: `mmio_kd`

## Requirements
- R1: `bus_sel` is 1 only in a cycle that has `bus_rd` or `bus_wr` asserted and an address equal to one of 0xF400 (keyboard status), 0xF401 (keyboard data), 0xF3FC (display status) or 0xF3FF (display data). In every other cycle `bus_sel` is 0.
- R2: When `kb_valid` is high at a clock edge, the keyboard data register takes `kb_byte`. From the next cycle, bit 15 of the keyboard status word reads 1.
- R3: A read of 0xF401 returns the stored byte in bits 7:0, and bit 15 of the keyboard status word is 0 afterwards. If a new byte arrives in the same cycle as that read, the read returns the old byte, bit 15 stays 1, and no overrun is recorded.
- R4: Bit 14 of the keyboard status word is set when a byte arrives while bit 15 is already 1 and that byte is not consumed in the same cycle. In that case the data register holds the newer byte. A keyboard status read clears bit 14. If a new overrun occurs in the same cycle as that read, the set takes priority.
- R5: A write to 0xF3FF loads bits 7:0 of `bus_wdata` into `dp_byte`, raises `dp_valid`, and clears bit 15 of the display status word from the next cycle. While `dp_valid` is high and `dp_ready` is low, `dp_byte` and `dp_valid` do not change.
- R6: A clock edge with both `dp_valid` and `dp_ready` high drops `dp_valid` and sets display status bit 15. If a write to 0xF3FF falls in that same cycle, the write takes priority: the new byte is presented, `dp_valid` stays 1 and bit 15 stays 0.
- R7: All bits that no flag or character uses read as 0. A read of 0xF3FF returns the last byte written in bits 7:0. When no read strobe is asserted, `bus_rdata` is 0.
- R8: Writes to 0xF400, 0xF401 and 0xF3FC change no register.
- R9: After reset the keyboard status reads 0x0000, the display status reads 0x8000, both data registers read 0x0000, and `dp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 16 | Processor address |
| bus_wdata | input | 16 | Processor write data |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_rdata | output | 16 | Read data, combinational |
| bus_sel | output | 1 | Block claims the current access |
| kb_byte | input | 8 | Character from keyboard |
| kb_valid | input | 1 | One-cycle strobe for kb_byte |
| dp_byte | output | 8 | Character to display |
| dp_valid | output | 1 | dp_byte is pending |
| dp_ready | input | 1 | Display accepts the pending byte |

## Verification
Two pairs of events can land on the same clock edge, and each pair is forced deliberately. The first pair is a keyboard byte arriving while the processor reads the keyboard data word. In that case the read must return the older byte, the ready flag must stay set, and no overrun may be recorded. The second pair is the display acknowledging its pending byte on the edge where the processor writes a new one. In that case the new byte must remain presented and the display must stay busy. Both cases are judged from later status and data reads, and from the display pins.

// File: rtl/mmio_kd_pkg.sv
// Package: register identities and fixed addresses of the keyboard/display window.
// Assumes a 16-bit address space; addresses are fixed by the system memory map.
package mmio_kd_pkg;
    localparam int NUM_REGS = 4;

    typedef enum logic [1:0] {
        REG_KSTAT = 2'd0,
        REG_KDATA = 2'd1,
        REG_DSTAT = 2'd2,
        REG_DDATA = 2'd3
    } reg_id_e;

    localparam logic [15:0] ADDR_KSTAT = 16'hF400;
    localparam logic [15:0] ADDR_KDATA = 16'hF401;
    localparam logic [15:0] ADDR_DSTAT = 16'hF3FC;
    localparam logic [15:0] ADDR_DDATA = 16'hF3FF;

    // Address of a register, indexed by its identity.
    function automatic logic [15:0] reg_addr(input int idx);
        case (idx)
            0:       return ADDR_KSTAT;
            1:       return ADDR_KDATA;
            2:       return ADDR_DSTAT;
            default: return ADDR_DDATA;
        endcase
    endfunction
endpackage

// File: rtl/mmio_kd_decode.sv
// Module: address decoder. Compares the bus address against each fixed
// register address and qualifies the match with the read and write strobes.
// Assumes at most one strobe is meaningful per cycle; purely combinational.
module mmio_kd_decode
    import mmio_kd_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [AW-1:0]       addr,
    input  logic                rd,
    input  logic                wr,
    output logic [NUM_REGS-1:0] rd_hit,
    output logic [NUM_REGS-1:0] wr_hit,
    output logic                sel
);
    logic [NUM_REGS-1:0] hit;

    // One comparator per device register.
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_cmp
        assign hit[g] = (addr == AW'(reg_addr(g)));
    end

    // Strobe qualification and claim signal.
    always_comb begin
        rd_hit = rd ? hit : '0;
        wr_hit = wr ? hit : '0;
        sel    = (rd | wr) & (|hit);
    end
endmodule

// File: rtl/mmio_kd_kbd.sv
// Module: keyboard channel. Holds the last received character, the ready
// flag and the sticky overrun flag. Assumes in_valid is a one-cycle strobe
// per character and that data_rd/stat_rd are decoded, strobe-qualified reads.
module mmio_kd_kbd #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] in_byte,
    input  logic          in_valid,
    input  logic          data_rd,
    input  logic          stat_rd,
    output logic          rdy,
    output logic          ovr,
    output logic [CW-1:0] data
);
    logic lost;

    // A character is lost only if the held one was neither read nor replaced-after-read.
    assign lost = in_valid & rdy & ~data_rd;

    // Capture character and maintain ready flag; arrival beats consumption.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data <= '0;
            rdy  <= 1'b0;
        end else if (in_valid) begin
            data <= in_byte;
            rdy  <= 1'b1;
        end else if (data_rd) begin
            rdy  <= 1'b0;
        end
    end

    // Sticky overrun: a new loss wins over the clearing status read.
    always_ff @(posedge clk) begin
        if (!rst_n)       ovr <= 1'b0;
        else if (lost)    ovr <= 1'b1;
        else if (stat_rd) ovr <= 1'b0;
    end
endmodule

// File: rtl/mmio_kd_disp.sv
// Module: display channel. Latches a written character, presents it with a
// valid/ready handshake and keeps the ready flag seen by software.
// Assumes data_wr is a decoded, strobe-qualified write to the data register.
module mmio_kd_disp #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          data_wr,
    input  logic [CW-1:0] wbyte,
    input  logic          out_ready,
    output logic          rdy,
    output logic          out_valid,
    output logic [CW-1:0] out_byte
);
    // Write launches a transfer; acknowledge completes it; write wins a tie.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_byte  <= '0;
            out_valid <= 1'b0;
            rdy       <= 1'b1;
        end else if (data_wr) begin
            out_byte  <= wbyte;
            out_valid <= 1'b1;
            rdy       <= 1'b0;
        end else if (out_valid && out_ready) begin
            out_valid <= 1'b0;
            rdy       <= 1'b1;
        end
    end
endmodule

// File: rtl/mmio_kd.sv
// Module: memory-mapped keyboard/display register window (top).
// Decodes four fixed addresses, routes side-effecting accesses to the two
// channels and multiplexes read data. Assumes single-cycle bus accesses with
// combinational read data; side effects occur at the edge ending the access.
module mmio_kd
    import mmio_kd_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          bus_rd,
    input  logic          bus_wr,
    output logic [DW-1:0] bus_rdata,
    output logic          bus_sel,
    input  logic [CW-1:0] kb_byte,
    input  logic          kb_valid,
    output logic [CW-1:0] dp_byte,
    output logic          dp_valid,
    input  logic          dp_ready
);
    localparam int RDY_BIT = DW - 1;
    localparam int OVR_BIT = DW - 2;

    logic [NUM_REGS-1:0] rd_hit;
    logic [NUM_REGS-1:0] wr_hit;
    logic                k_rdy;
    logic                k_ovr;
    logic [CW-1:0]       k_data;
    logic                d_rdy;

    mmio_kd_decode #(.AW(AW)) u_dec (
        .addr   (bus_addr),
        .rd     (bus_rd),
        .wr     (bus_wr),
        .rd_hit (rd_hit),
        .wr_hit (wr_hit),
        .sel    (bus_sel)
    );

    mmio_kd_kbd #(.CW(CW)) u_kbd (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_byte  (kb_byte),
        .in_valid (kb_valid),
        .data_rd  (rd_hit[REG_KDATA]),
        .stat_rd  (rd_hit[REG_KSTAT]),
        .rdy      (k_rdy),
        .ovr      (k_ovr),
        .data     (k_data)
    );

    mmio_kd_disp #(.CW(CW)) u_disp (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_wr   (wr_hit[REG_DDATA]),
        .wbyte     (bus_wdata[CW-1:0]),
        .out_ready (dp_ready),
        .rdy       (d_rdy),
        .out_valid (dp_valid),
        .out_byte  (dp_byte)
    );

    // Read multiplexer; unused bits and unselected cycles return zero.
    always_comb begin
        bus_rdata = '0;
        if (rd_hit[REG_KSTAT]) begin
            bus_rdata[RDY_BIT] = k_rdy;
            bus_rdata[OVR_BIT] = k_ovr;
        end
        if (rd_hit[REG_KDATA]) bus_rdata[CW-1:0] = k_data;
        if (rd_hit[REG_DSTAT]) bus_rdata[RDY_BIT] = d_rdy;
        if (rd_hit[REG_DDATA]) bus_rdata[CW-1:0] = dp_byte;
    end
endmodule

// File: rtl/mmio_kd_chk.sv
// Module: assertion checker for mmio_kd, attached by bind below.
// Observes ports and the channel flags that separate logic drives.
module mmio_kd_chk #(
    parameter int AW = 16,
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] bus_addr,
    input logic          bus_rd,
    input logic          bus_wr,
    input logic          bus_sel,
    input logic          kb_valid,
    input logic [CW-1:0] dp_byte,
    input logic          dp_valid,
    input logic          dp_ready,
    input logic          k_rdy,
    input logic          k_ovr,
    input logic          d_rdy
);
    logic kd_rd;
    logic dd_wr;
    assign kd_rd = bus_rd && (bus_addr == AW'(16'hF401));
    assign dd_wr = bus_wr && (bus_addr == AW'(16'hF3FF));

    // R1
    no_idle_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd || bus_wr) |-> !bus_sel);
    // R1
    no_foreign_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != AW'(16'hF400) && bus_addr != AW'(16'hF401) &&
         bus_addr != AW'(16'hF3FC) && bus_addr != AW'(16'hF3FF)) |-> !bus_sel);
    // R2
    kb_ready_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kb_valid |=> k_rdy);
    // R3
    kb_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kd_rd && !kb_valid) |=> !k_rdy);
    // R4
    kb_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kb_valid && k_rdy && !kd_rd) |=> k_ovr);
    // R5
    dp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_valid && !dp_ready && !dd_wr) |=> (dp_valid && $stable(dp_byte)));
    // R6
    dp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dp_valid && d_rdy));
    // R6
    dp_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_valid && dp_ready && !dd_wr) |=> (!dp_valid && d_rdy));
endmodule

bind mmio_kd mmio_kd_chk #(.AW(AW), .CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .bus_sel  (bus_sel),
    .kb_valid (kb_valid),
    .dp_byte  (dp_byte),
    .dp_valid (dp_valid),
    .dp_ready (dp_ready),
    .k_rdy    (k_rdy),
    .k_ovr    (k_ovr),
    .d_rdy    (d_rdy)
);

// File: tb/mmio_kd_bench.sv
// Bench: sweeps every character through both channels, probes the address
// neighbourhood and forces the two same-edge collisions.
module mmio_kd_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_rdata;
    logic        bus_sel;
    logic [7:0]  kb_byte = '0;
    logic        kb_valid = 1'b0;
    logic [7:0]  dp_byte;
    logic        dp_valid;
    logic        dp_ready = 1'b0;

    int nchk = 0;
    int nbad = 0;
    logic [15:0] got;
    logic        gsel;

    always #2.5 clk = ~clk;

    mmio_kd u_mmio_kd (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata), .bus_sel(bus_sel),
        .kb_byte(kb_byte), .kb_valid(kb_valid), .dp_byte(dp_byte),
        .dp_valid(dp_valid), .dp_ready(dp_ready)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Single-cycle read; samples combinational data before the edge.
    task automatic rd(input logic [15:0] a);
        bus_addr = a; bus_rd = 1'b1;
        #1; got = bus_rdata; gsel = bus_sel;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        #1; gsel = bus_sel;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic key(input logic [7:0] b);
        kb_byte = b; kb_valid = 1'b1;
        @(posedge clk); #1;
        kb_valid = 1'b0;
    endtask

    task automatic idle();
        @(posedge clk); #1;
    endtask

    initial begin
        #(200000 * 5);
        nbad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R9 reset values
        check("R9 dp_valid", {15'b0, dp_valid}, 16'h0);
        check("R7 idle rdata", bus_rdata, 16'h0);
        rd(16'hF400); check("R9 kstat", got, 16'h0000);
        rd(16'hF401); check("R9 kdata", got, 16'h0000);
        rd(16'hF3FC); check("R9 dstat", got, 16'h8000);
        rd(16'hF3FF); check("R9 ddata", got, 16'h0000);

        // R1 claim on the four addresses only, sweep neighbourhood
        for (int a = 16'hF3F0; a <= 16'hF40F; a++) begin
            logic exp_sel;
            exp_sel = (a == 16'hF400) || (a == 16'hF401) || (a == 16'hF3FC) || (a == 16'hF3FF);
            rd(16'(a));
            check("R1 sel", {15'b0, gsel}, {15'b0, exp_sel});
            if (!exp_sel) check("R7 unclaimed rdata", got, 16'h0);
        end
        bus_addr = 16'hF400; #1;
        check("R1 no strobe sel", {15'b0, bus_sel}, 16'h0);
        idle();

        // R2 R3 every character through the keyboard
        for (int b = 0; b < 256; b++) begin
            key(8'(b));
            rd(16'hF400); check("R2 kstat ready", got, 16'h8000);
            rd(16'hF401); check("R3 kdata", got, {8'h00, 8'(b)});
            rd(16'hF400); check("R3 kstat cleared", got, 16'h0000);
        end

        // R4 overrun, newer byte kept, status read clears
        key(8'h41); key(8'h42);
        rd(16'hF400); check("R4 overrun set", got, 16'hC000);
        rd(16'hF400); check("R4 overrun cleared", got, 16'h8000);
        rd(16'hF401); check("R4 newer byte", got, 16'h0042);
        // R4 set wins over clearing status read
        key(8'h10); key(8'h11);
        kb_byte = 8'h12; kb_valid = 1'b1;
        rd(16'hF400); kb_valid = 1'b0;
        check("R4 read during overrun", got, 16'hC000);
        rd(16'hF400); check("R4 set beats clear", got, 16'hC000);
        rd(16'hF401); check("R4 latest", got, 16'h0012);
        rd(16'hF400); check("R4 drained", got, 16'h0000);

        // R3 arrival in the same cycle as data read
        key(8'h55);
        kb_byte = 8'h66; kb_valid = 1'b1;
        rd(16'hF401); kb_valid = 1'b0;
        check("R3 collision old byte", got, 16'h0055);
        rd(16'hF400); check("R3 collision still ready", got, 16'h8000);
        rd(16'hF401); check("R3 collision new byte", got, 16'h0066);

        // R8 writes to keyboard registers and display status ignored
        key(8'h7E);
        wr(16'hF400, 16'hFFFF);
        check("R8 write sel", {15'b0, gsel}, 16'h1);
        wr(16'hF401, 16'h1234);
        wr(16'hF3FC, 16'h0000);
        rd(16'hF400); check("R8 kstat kept", got, 16'h8000);
        rd(16'hF401); check("R8 kdata kept", got, 16'h007E);
        rd(16'hF3FC); check("R8 dstat kept", got, 16'h8000);
        check("R8 no display launch", {15'b0, dp_valid}, 16'h0);

        // R5 R6 every character through the display
        for (int b = 0; b < 256; b++) begin
            wr(16'hF3FF, {8'hA5, 8'(b)});
            check("R5 dp_valid", {15'b0, dp_valid}, 16'h1);
            check("R5 dp_byte", {8'h00, dp_byte}, {8'h00, 8'(b)});
            rd(16'hF3FC); check("R5 dstat busy", got, 16'h0000);
            check("R5 hold byte", {8'h00, dp_byte}, {8'h00, 8'(b)});
            rd(16'hF3FF); check("R7 ddata", got, {8'h00, 8'(b)});
            dp_ready = 1'b1; idle(); dp_ready = 1'b0;
            check("R6 valid dropped", {15'b0, dp_valid}, 16'h0);
            rd(16'hF3FC); check("R6 dstat ready", got, 16'h8000);
        end

        // R6 write collides with acknowledge
        wr(16'hF3FF, 16'h0031);
        dp_ready = 1'b1;
        wr(16'hF3FF, 16'h0032);
        dp_ready = 1'b0;
        check("R6 collision valid", {15'b0, dp_valid}, 16'h1);
        check("R6 collision byte", {8'h00, dp_byte}, 16'h0032);
        rd(16'hF3FC); check("R6 collision busy", got, 16'h0000);
        dp_ready = 1'b1; idle(); dp_ready = 1'b0;
        rd(16'hF3FC); check("R6 final ready", got, 16'h8000);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end
endmodule